// File: doc/BRIEF.md
# Power Reset Cascade Controller

This block produces the reset tree of a small microcontroller. Three nested reset levels are generated. The outermost is the brownout reset. It covers the whole device and also drives the active-low external reset pin low. The middle level is the power-on reset. The innermost is the power-up clear. A higher level always pulls in the levels below it. Each level is stretched for a minimum number of clock cycles after its cause goes away, and the levels come out of reset one clock apart, outermost first.

The supply supervisors and the brownout detector sit outside the block. Their results arrive as synchronous digital inputs: a high-side level-met flag, a low-side level-met flag, and a raw brownout trip. Each supervisor has an enable bit, and both enable bits are set at power-up.

Software uses a small register port with four addresses:

- A control register at address 0 holds two trigger bits that clear themselves, one for a software brownout and one for a software power-on reset. It also holds the two supervisor enables.
- A flag register at address 1 records which kind of reset happened. The flags survive the reset cascade.
- A cause register at address 2 reports the highest-priority recorded reset and clears that one flag when it is read.

The block has one asynchronous input, `arst_n`, which stands for the supply ramp itself. It is the only thing that returns the register state to its initial values.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: While `arst_n` is low, `rst_bor`, `rst_por` and `rst_puc` are 1 and `ext_rst_n` is 0. The control register (address 0) reads 0x30, meaning the high-side enable (bit 4) and the low-side enable (bit 5) are both set. The flag register (address 1) reads 0x00.
- R2: A brownout cause asserts `rst_bor` one cycle after it is sampled, and `rst_bor` stays asserted for as long as the cause lasts. A brownout cause is any of the following: `bod_trip` high, regardless of the enable bits; `svs_hi_ok` low while bit 4 is set; `svs_lo_ok` low while bit 5 is set.
- R3: A supervisor whose enable bit is 0 has no effect. Its level-met input going low asserts no reset and sets no flag.
- R4: Writing 1 to control bit 0 causes a brownout reset and sets the brownout flag (flag bit 0). Writing 1 to control bit 1 causes a power-on reset without a brownout reset and sets the power-on flag (flag bit 1). Any brownout cause also sets flag bit 0.
- R5: Control bits 0 and 1 always read back as 0.
- R6: When `rst_bor` is high, `rst_por` is high in the next cycle. When `rst_por` is high, `rst_puc` is high in the next cycle.
- R7: After the last cycle in which a level's own cause is sampled, that level stays asserted for `HOLD_CYCLES` cycles (default 8). The level below it is released exactly one cycle later, and the level below that one cycle after that.
- R8: `ext_rst_n` is 0 in exactly the cycles in which `rst_bor` is 1.
- R9: In the flag register, writing a 1 to a bit clears that flag. Writing a 0 leaves the flag unchanged.
- R10: A read of address 2 returns 0x02 if the brownout flag is set. Otherwise it returns 0x04 if the power-on flag is set, and 0x00 if neither is set. The read clears only the flag it reported.
- R11: Resets generated by the block itself never clear the flags. Only `arst_n` does.
- R12: If a flag is set and cleared in the same cycle, whether the clear comes from a write or from a cause read, the set wins.

Bit positions and addresses not named above (control bits 2, 3, 6 and 7, flag bits 2 to 7, and address 3) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous supply-ramp reset, active low |
| svs_hi_ok | input | 1 | High-side supervisor level met |
| svs_lo_ok | input | 1 | Low-side supervisor level met |
| bod_trip | input | 1 | Raw brownout detect, 1 means the supply is insufficient |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; reading the cause register has side effects |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| rst_bor | output | 1 | Brownout reset, active high |
| rst_por | output | 1 | Power-on reset, active high |
| rst_puc | output | 1 | Power-up clear, active high |
| ext_rst_n | output | 1 | External reset pin drive, 0 pulls the pin low |

## Verification
The hazardous overlap is a brownout flag being set and being cleared in the same cycle. The clear can come from a cause-register read or from a write-one-to-clear. The bench holds `bod_trip` high and performs both kinds of clear while the trip is active. The cause read must still return 0x02, and the flag register read after it must still show bit 0. Once the trip has gone away, the bench issues one more write-one-to-clear and expects the flag to go to zero.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

    localparam int DW   = 8;
    localparam int AW   = 2;
    localparam int NLVL = 3;

    localparam int LVL_BOR = 0;
    localparam int LVL_POR = 1;
    localparam int LVL_PUC = 2;

    localparam logic [AW-1:0] A_CTRL  = 2'd0;
    localparam logic [AW-1:0] A_FLAG  = 2'd1;
    localparam logic [AW-1:0] A_CAUSE = 2'd2;

    localparam int CTRL_SWB = 0;
    localparam int CTRL_SWP = 1;
    localparam int CTRL_HEN = 4;
    localparam int CTRL_LEN = 5;

    localparam int FLAG_B = 0;
    localparam int FLAG_P = 1;

    localparam logic [DW-1:0] CODE_NONE = 8'h00;
    localparam logic [DW-1:0] CODE_BOR  = 8'h02;
    localparam logic [DW-1:0] CODE_POR  = 8'h04;

    typedef struct packed {
        logic sw_bor;
        logic sw_por;
        logic hi_en;
        logic lo_en;
        logic bor_flg;
        logic por_flg;
    } regs_t;

endpackage

// File: rtl/rst_stretch.sv
module rst_stretch #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic cause,
    input  logic upper,
    output logic act
);
    localparam int CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cause) begin
            s_d.cnt = CW'(HOLD);
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        s_d.act = cause | upper | (s_q.cnt > CW'(1));
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s_q.act <= 1'b1;
            s_q.cnt <= CW'(HOLD);
        end else begin
            s_q <= s_d;
        end
    end

    assign act = s_q.act;

    // R2: a sampled cause holds the level in the following cycle
    p_cause_holds_r2: assert property (@(posedge clk) disable iff (!arst_n)
        cause |=> act);

    // R6: the enclosing level drags this one along
    p_upper_drags_r6: assert property (@(posedge clk) disable iff (!arst_n)
        upper |=> act);

    // R7: release only after neither input was present in the prior cycle
    p_release_clean_r7: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(act) |-> ($past(!cause) && $past(!upper)));

endmodule

// File: rtl/rst_regs.sv
module rst_regs
    import pwr_rst_pkg::*;
(
    input  logic          clk,
    input  logic          arst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          bor_evt,
    output logic          sw_bor,
    output logic          sw_por,
    output logic          hi_en,
    output logic          lo_en
);
    regs_t r_d, r_q;
    logic  wr_ctrl, wr_flag, rd_cause, pick_bor, pick_por;
    logic  wdata_unused;

    assign wdata_unused = ^{bus_wdata[7:6], bus_wdata[3:2]};

    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
        wr_flag  = bus_wr && (bus_addr == A_FLAG);
        rd_cause = bus_rd && (bus_addr == A_CAUSE);
        pick_bor = rd_cause && r_q.bor_flg;
        pick_por = rd_cause && !r_q.bor_flg && r_q.por_flg;

        r_d        = r_q;
        r_d.sw_bor = wr_ctrl && bus_wdata[CTRL_SWB];
        r_d.sw_por = wr_ctrl && bus_wdata[CTRL_SWP];
        if (wr_ctrl) begin
            r_d.hi_en = bus_wdata[CTRL_HEN];
            r_d.lo_en = bus_wdata[CTRL_LEN];
        end

        if ((wr_flag && bus_wdata[FLAG_B]) || pick_bor) r_d.bor_flg = 1'b0;
        if (bor_evt)                                    r_d.bor_flg = 1'b1;

        if ((wr_flag && bus_wdata[FLAG_P]) || pick_por) r_d.por_flg = 1'b0;
        if (r_q.sw_por)                                 r_d.por_flg = 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CTRL_HEN] = r_q.hi_en;
                bus_rdata[CTRL_LEN] = r_q.lo_en;
            end
            A_FLAG: begin
                bus_rdata[FLAG_B] = r_q.bor_flg;
                bus_rdata[FLAG_P] = r_q.por_flg;
            end
            A_CAUSE: begin
                if (r_q.bor_flg)      bus_rdata = CODE_BOR;
                else if (r_q.por_flg) bus_rdata = CODE_POR;
                else                  bus_rdata = CODE_NONE;
            end
            default: bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            r_q.sw_bor  <= 1'b0;
            r_q.sw_por  <= 1'b0;
            r_q.hi_en   <= 1'b1;
            r_q.lo_en   <= 1'b1;
            r_q.bor_flg <= 1'b0;
            r_q.por_flg <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sw_bor = r_q.sw_bor;
    assign sw_por = r_q.sw_por;
    assign hi_en  = r_q.hi_en;
    assign lo_en  = r_q.lo_en;

    // R10: a cause read removes the reported brownout flag
    p_cause_clears_bor_r10: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_cause && r_q.bor_flg && !bor_evt) |=> !r_q.bor_flg);

    // R10: the lower-priority flag survives that read
    p_cause_keeps_por_r10: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_cause && r_q.bor_flg && r_q.por_flg && !bus_wr) |=> r_q.por_flg);

    // R12: an event in the same cycle as any clear leaves the flag set
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!arst_n)
        bor_evt |=> r_q.bor_flg);

    // R4: a software power-on trigger records its flag
    p_por_flag_r4: assert property (@(posedge clk) disable iff (!arst_n)
        r_q.sw_por |=> r_q.por_flg);

endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
    import pwr_rst_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          svs_hi_ok,
    input  logic          svs_lo_ok,
    input  logic          bod_trip,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rst_bor,
    output logic          rst_por,
    output logic          rst_puc,
    output logic          ext_rst_n
);
    logic            sw_bor, sw_por, hi_en, lo_en;
    logic            bor_cause;
    logic [NLVL-1:0] lvl_cause, lvl_up, lvl_act;

    rst_regs u_regs (
        .clk       (clk),
        .arst_n    (arst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bor_evt   (bor_cause),
        .sw_bor    (sw_bor),
        .sw_por    (sw_por),
        .hi_en     (hi_en),
        .lo_en     (lo_en)
    );

    always_comb begin
        bor_cause = bod_trip
                  | (hi_en & ~svs_hi_ok)
                  | (lo_en & ~svs_lo_ok)
                  | sw_bor;
        lvl_cause          = '0;
        lvl_cause[LVL_BOR] = bor_cause;
        lvl_cause[LVL_POR] = sw_por;
    end

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        if (g == 0) begin : g_top
            assign lvl_up[g] = 1'b0;
        end else begin : g_inner
            assign lvl_up[g] = lvl_act[g-1];
        end
        rst_stretch #(.HOLD(HOLD_CYCLES)) u_stretch (
            .clk    (clk),
            .arst_n (arst_n),
            .cause  (lvl_cause[g]),
            .upper  (lvl_up[g]),
            .act    (lvl_act[g])
        );
    end

    assign rst_bor   = lvl_act[LVL_BOR];
    assign rst_por   = lvl_act[LVL_POR];
    assign rst_puc   = lvl_act[LVL_PUC];
    assign ext_rst_n = ~lvl_act[LVL_BOR];

    // R6: cascade from brownout into power-on
    p_por_follows_r6: assert property (@(posedge clk) disable iff (!arst_n)
        rst_bor |=> rst_por);

    // R6: cascade from power-on into power-up clear
    p_puc_follows_r6: assert property (@(posedge clk) disable iff (!arst_n)
        rst_por |=> rst_puc);

    // R7: power-on leaves reset only once brownout is already out
    p_order_por_r7: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_por) |-> !rst_bor);

    // R7: power-up clear leaves reset only once power-on is already out
    p_order_puc_r7: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_puc) |-> !rst_por);

    // R8: a brownout cause pulls the pin low in the next cycle
    p_pin_low_r8: assert property (@(posedge clk) disable iff (!arst_n)
        bor_cause |=> !ext_rst_n);

endmodule

// File: tb/pwr_rst_ctrl_test.sv
module pwr_rst_ctrl_test;
    localparam int CLK_P = 10;
    localparam int HOLD  = 8;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       svs_hi_ok = 1'b1, svs_lo_ok = 1'b0, bod_trip = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rst_bor, rst_por, rst_puc, ext_rst_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pwr_rst_ctrl #(.HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .arst_n(arst_n), .svs_hi_ok(svs_hi_ok), .svs_lo_ok(svs_lo_ok),
        .bod_trip(bod_trip), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_bor(rst_bor),
        .rst_por(rst_por), .rst_puc(rst_puc), .ext_rst_n(ext_rst_n)
    );

    task automatic chk(input int act, input int exp, input string req, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 8'd0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // samples at n successive falling edges; first/last index of high, -1 if none
    task automatic observe(input int n,
                           output int bf, output int bl, output int pf, output int pl,
                           output int uf, output int ul, output int bcnt, output int pcnt,
                           output int pin_bad);
        bf = -1; bl = -1; pf = -1; pl = -1; uf = -1; ul = -1;
        bcnt = 0; pcnt = 0; pin_bad = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (rst_bor) begin if (bf < 0) bf = i; bl = i; bcnt++; end
            if (rst_por) begin if (pf < 0) pf = i; pl = i; pcnt++; end
            if (rst_puc) begin if (uf < 0) uf = i; ul = i; end
            if (ext_rst_n == rst_bor) pin_bad++;
        end
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        idle(3);
        chk(rst_bor, 1, "R1", "bor in reset");
        chk(rst_por, 1, "R1", "por in reset");
        chk(rst_puc, 1, "R1", "puc in reset");
        chk(ext_rst_n, 0, "R1", "pin in reset");
        bus_read(2'd0, d); chk(d, 8'h30, "R1", "ctrl reset value");
        bus_read(2'd1, d); chk(d, 8'h00, "R1", "flag reset value");
    endtask

    task automatic t_powerup();
        int bf, bl, pf, pl, uf, ul, bc, pc, pb;
        logic [7:0] d;
        @(negedge clk); arst_n = 1'b1;
        observe(20, bf, bl, pf, pl, uf, ul, bc, pc, pb);
        chk(bc, 20, "R2", "bor held while low side unmet");
        @(negedge clk); svs_lo_ok = 1'b1; svs_hi_ok = 1'b0;
        observe(20, bf, bl, pf, pl, uf, ul, bc, pc, pb);
        chk(bc, 20, "R2", "bor held while high side unmet");
        @(negedge clk); svs_hi_ok = 1'b1;
        observe(2*HOLD + 6, bf, bl, pf, pl, uf, ul, bc, pc, pb);
        chk(bc, HOLD - 1, "R7", "bor stretch after both levels met");
        chk(pl, bl + 1, "R7", "por released one cycle after bor");
        chk(ul, bl + 2, "R7", "puc released two cycles after bor");
        chk(pb, 0, "R8", "pin mismatches at power-up");
        bus_read(2'd1, d); chk(d, 8'h01, "R4", "brownout flag after power-up");
        bus_read(2'd2, d); chk(d, 8'h02, "R10", "cause vector brownout");
        bus_read(2'd1, d); chk(d, 8'h00, "R10", "flag cleared by cause read");
    endtask

    task automatic t_sw_bor();
        int bf, bl, pf, pl, uf, ul, bc, pc, pb;
        logic [7:0] d;
        bus_write(2'd0, 8'h31);
        observe(HOLD + 12, bf, bl, pf, pl, uf, ul, bc, pc, pb);
        chk(bc, HOLD, "R7", "sw brownout stretch length");
        chk(pf, bf + 1, "R6", "por follows bor");
        chk(uf, bf + 2, "R6", "puc follows por");
        chk(pl, bl + 1, "R7", "por release order");
        chk(ul, bl + 2, "R7", "puc release order");
        chk(pb, 0, "R8", "pin mismatches on sw brownout");
        bus_read(2'd0, d); chk(d, 8'h30, "R5", "trigger bits read back zero");
        bus_read(2'd1, d); chk(d, 8'h01, "R4", "sw brownout sets flag");
    endtask

    task automatic t_sw_por();
        int bf, bl, pf, pl, uf, ul, bc, pc, pb;
        logic [7:0] d;
        bus_write(2'd0, 8'h32);
        observe(HOLD + 12, bf, bl, pf, pl, uf, ul, bc, pc, pb);
        chk(bc, 0, "R4", "sw power-on does not brown out");
        chk(pc, HOLD, "R7", "sw power-on stretch length");
        chk(uf, pf + 1, "R6", "puc follows por");
        chk(ul, pl + 1, "R7", "puc release after por");
        bus_read(2'd0, d); chk(d, 8'h30, "R5", "por trigger reads zero");
        bus_read(2'd1, d); chk(d, 8'h03, "R11", "flags survive cascade");
    endtask

    task automatic t_flags_w1c();
        logic [7:0] d;
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, d); chk(d, 8'h03, "R9", "zero write leaves flags");
        bus_write(2'd1, 8'h02);
        bus_read(2'd1, d); chk(d, 8'h01, "R9", "clear power-on flag only");
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, d); chk(d, 8'h00, "R9", "clear brownout flag");
    endtask

    task automatic t_vector();
        logic [7:0] d;
        bus_read(2'd2, d); chk(d, 8'h00, "R10", "vector with no flags");
        bus_write(2'd0, 8'h31); idle(HOLD + 8);
        bus_write(2'd0, 8'h32); idle(HOLD + 8);
        bus_read(2'd2, d); chk(d, 8'h02, "R10", "brownout has priority");
        bus_read(2'd1, d); chk(d, 8'h02, "R10", "only brownout flag cleared");
        bus_read(2'd2, d); chk(d, 8'h04, "R10", "power-on code next");
        bus_read(2'd1, d); chk(d, 8'h00, "R10", "power-on flag cleared");
        bus_read(2'd2, d); chk(d, 8'h00, "R10", "vector empty again");
    endtask

    task automatic t_enables();
        int bf, bl, pf, pl, uf, ul, bc, pc, pb;
        logic [7:0] d;
        bus_write(2'd0, 8'h20);
        @(negedge clk); svs_hi_ok = 1'b0;
        observe(20, bf, bl, pf, pl, uf, ul, bc, pc, pb);
        chk(bc, 0, "R3", "disabled high side ignored");
        chk(pc, 0, "R3", "no power-on from disabled side");
        @(negedge clk); svs_hi_ok = 1'b1;
        bus_write(2'd0, 8'h10);
        @(negedge clk); svs_lo_ok = 1'b0;
        observe(20, bf, bl, pf, pl, uf, ul, bc, pc, pb);
        chk(bc, 0, "R3", "disabled low side ignored");
        @(negedge clk); svs_lo_ok = 1'b1;
        bus_read(2'd1, d); chk(d, 8'h00, "R3", "no flag from disabled side");
        bus_write(2'd0, 8'h30);
        svs_lo_ok = 1'b0;
        @(negedge clk); svs_lo_ok = 1'b1;
        observe(HOLD + 10, bf, bl, pf, pl, uf, ul, bc, pc, pb);
        chk(bc, HOLD - 1, "R2", "one-cycle low-side drop stretched");
        bus_write(2'd0, 8'h00);
        bod_trip = 1'b1;
        @(negedge clk); bod_trip = 1'b0;
        observe(HOLD + 10, bf, bl, pf, pl, uf, ul, bc, pc, pb);
        chk(bc, HOLD - 1, "R2", "raw brownout with supervisors off");
        bus_write(2'd0, 8'h30);
        bus_write(2'd1, 8'h03);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        bus_read(2'd1, d); chk(d, 8'h00, "R12", "flags clear before overlap");
        @(negedge clk); bod_trip = 1'b1;
        idle(3);
        bus_read(2'd2, d); chk(d, 8'h02, "R12", "vector during trip");
        bus_read(2'd1, d); chk(d, 8'h01, "R12", "set beats cause-read clear");
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, d); chk(d, 8'h01, "R12", "set beats write clear");
        chk(ext_rst_n, 0, "R8", "pin low during trip");
        @(negedge clk); bod_trip = 1'b0;
        idle(HOLD + 6);
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, d); chk(d, 8'h00, "R9", "clear after trip ends");
        chk(ext_rst_n, 1, "R8", "pin released");
    endtask

    initial begin
        t_reset_state();
        t_powerup();
        t_sw_bor();
        t_sw_por();
        t_flags_w1c();
        t_vector();
        t_enables();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule